// File: doc/BRIEF.md
# Interlaced Field Scanout Address Generator

This block produces the memory read addresses needed to scan a progressive frame buffer out as two interlaced fields. A field timing generator supplies the field parity, a line-start pulse and an active-pixel strobe; the block answers with a luma address and, for the three-plane 4:2:0 layout, two chroma-plane addresses for the pixel being fetched in that cycle. Packed RGB (15, 16 and 32 bits per pixel), packed 4:2:2 and three-plane 4:2:0 in either chroma-plane order are handled.

The frame description (base, pitch, height, depth code, byte-order and plane-order flags) is captured by a host write into a shadow copy. It becomes live only at a field boundary, which is a change of the parity input, so a buffer flip never splits a field. A write that lands close to the end of a field waits one extra field, so software always has a safe margin.

Top module: `field_scan_addr_gen`

## Requirements
- R1: Odd-parity fields (field_i = 1) start luma at the base address; even-parity fields (field_i = 0) start luma at base + pitch.
- R2: Within a field, each new line's luma start is two pitches above the previous line's start.
- R3: With depth code 3'b111 and plane-order flag 0, the first chroma plane (u_addr_o) starts at base + height × pitch for odd fields and that value + pitch/2 for even fields; the second (v_addr_o) starts (height/2) × (pitch/2) above the first, with the same pitch/2 offset for even fields.
- R4: With depth code 3'b111 and plane-order flag 1, the two chroma start computations are exchanged between u_addr_o and v_addr_o.
- R5: In 4:2:0 mode the chroma line start advances by one pitch on every second line of a field (lines 0 and 1 share, lines 2 and 3 share, and so on).
- R6: Each active-pixel cycle advances luma by the pixel size of the live depth code: 3'b001 and 3'b010 and 3'b101 give 2 bytes, 3'b100 gives 4 bytes, 3'b111 gives 1 byte.
- R7: In 4:2:0 mode the chroma addresses advance by one byte for every two active pixels, starting fresh on each line; in every other valid mode u_addr_o and v_addr_o are zero.
- R8: filt_en_o is high exactly when the live depth code is 3'b101 or 3'b111; uyvy_o is high only when the live depth code is 3'b101 and the captured byte-order flag is set.
- R9: A live depth code of 3'b000, 3'b011 or 3'b110 raises fmt_err_o and drives all three addresses to the base address.
- R10: A host write commits at the next parity change; the field in progress keeps the previous settings.
- R11: A host write issued when the count of line starts since the last boundary plus GUARD_LINES is at least field_lines_i is not committed at the next boundary but at the one after it.
- R12: After reset all address outputs are zero and fmt_err_o, filt_en_o and uyvy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Host write strobe capturing the configuration inputs |
| base_i | input | ADDR_W | Frame buffer base address |
| pitch_i | input | PITCH_W | Bytes per frame line |
| height_i | input | HEIGHT_W | Frame height in lines |
| depth_i | input | 3 | Depth code |
| uyvy_i | input | 1 | Byte-order flag for packed 4:2:2 |
| yv12_i | input | 1 | Chroma plane-order flag for 4:2:0 |
| field_lines_i | input | LINE_W | Lines per field, used for the late-write window |
| field_i | input | 1 | Field parity from the timing generator |
| line_start_i | input | 1 | Pulse ahead of each line's active pixels |
| pix_i | input | 1 | Active-pixel strobe |
| y_addr_o | output | ADDR_W | Luma address of the current pixel |
| u_addr_o | output | ADDR_W | First chroma-plane address |
| v_addr_o | output | ADDR_W | Second chroma-plane address |
| filt_en_o | output | 1 | Chroma filter and dither enable |
| uyvy_o | output | 1 | UYVY byte order in effect |
| fmt_err_o | output | 1 | Unsupported depth code in effect |

## Verification
A corrupted line or pixel accumulator shows as a wrong address on the very next active-pixel cycle and stays wrong for the rest of the field, since every later address is built on it; a fault in the chroma line step first appears on the third line of a field. A wrong commit flag shows one field early or late, on the first pixel of that field, as a whole set of addresses belonging to the other configuration. The scoreboard compares every active pixel against addresses computed from the requirements, so each such fault is caught on its first visible cycle.

// File: rtl/fsag_pkg.sv
package fsag_pkg;
  parameter int ADDR_W   = 32;
  parameter int PITCH_W  = 16;
  parameter int HEIGHT_W = 12;

  typedef logic [2:0] depth_t;
  localparam depth_t DEPTH_RGB15 = 3'b001;
  localparam depth_t DEPTH_RGB16 = 3'b010;
  localparam depth_t DEPTH_RGB32 = 3'b100;
  localparam depth_t DEPTH_PK422 = 3'b101;
  localparam depth_t DEPTH_PL420 = 3'b111;

  typedef struct packed {
    logic [ADDR_W-1:0]   base;
    logic [PITCH_W-1:0]  pitch;
    logic [HEIGHT_W-1:0] height;
    depth_t              depth;
    logic                uyvy;
    logic                yv12;
  } scan_cfg_t;

  function automatic logic [2:0] bytes_per_pix(depth_t d);
    case (d)
      DEPTH_RGB15, DEPTH_RGB16, DEPTH_PK422: return 3'd2;
      DEPTH_RGB32:                           return 3'd4;
      DEPTH_PL420:                           return 3'd1;
      default:                               return 3'd0;
    endcase
  endfunction

  function automatic logic depth_ok(depth_t d);
    return bytes_per_pix(d) != 3'd0;
  endfunction

  function automatic logic depth_yuv(depth_t d);
    return (d == DEPTH_PK422) || (d == DEPTH_PL420);
  endfunction
endpackage

// File: rtl/fsag_shadow.sv
module fsag_shadow
  import fsag_pkg::*;
#(
  parameter int LINE_W      = 12,
  parameter int GUARD_LINES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  scan_cfg_t         wr_cfg_i,
  input  logic              bnd_i,
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] field_lines_i,
  output scan_cfg_t         live_o,
  output scan_cfg_t         nxt_o
);
  localparam int LW1 = LINE_W + 1;

  scan_cfg_t         shadow_q, live_q;
  logic              pend_q, late_q;
  logic [LINE_W-1:0] line_cnt_q;
  logic              late_zone;

  assign late_zone = ({1'b0, line_cnt_q} + LW1'(GUARD_LINES)) >= {1'b0, field_lines_i};
  assign nxt_o     = (bnd_i && pend_q) ? shadow_q : live_q;
  assign live_o    = live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_cnt_q <= '0;
    end else if (bnd_i) begin
      line_cnt_q <= '0;
    end else if (line_start_i) begin
      line_cnt_q <= line_cnt_q + LINE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q       <= '0;
      live_q         <= '0;
      live_q.depth   <= DEPTH_RGB32;
      shadow_q.depth <= DEPTH_RGB32;
      pend_q         <= 1'b0;
      late_q         <= 1'b0;
    end else begin
      if (bnd_i) begin
        live_q <= nxt_o;
        if (pend_q) begin
          pend_q <= 1'b0;
        end else if (late_q) begin
          pend_q <= 1'b1;
          late_q <= 1'b0;
        end
      end
      if (wr_i) begin
        shadow_q <= wr_cfg_i;
        // boundary cycle counts as line 0 of the new field
        if (late_zone && !bnd_i) begin
          late_q <= 1'b1;
          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b1;
          late_q <= 1'b0;
        end
      end
    end
  end

  AST_LIVE_ONLY_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> $stable(live_q)); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && late_q)); // R11
endmodule

// File: rtl/fsag_start_calc.sv
module fsag_start_calc
  import fsag_pkg::*;
(
  input  scan_cfg_t         cfg_i,
  input  logic              field_i,
  output logic [ADDR_W-1:0] y_start_o,
  output logic [ADDR_W-1:0] u_start_o,
  output logic [ADDR_W-1:0] v_start_o
);
  logic [ADDR_W-1:0] pitch_w, half_w, plane_a, plane_b, off_c;

  always_comb begin
    pitch_w = ADDR_W'(cfg_i.pitch);
    half_w  = pitch_w >> 1;
    plane_a = cfg_i.base + ADDR_W'(cfg_i.height) * pitch_w;
    plane_b = plane_a + ADDR_W'(cfg_i.height >> 1) * half_w;
    off_c   = field_i ? '0 : half_w;
    y_start_o = cfg_i.base + (field_i ? '0 : pitch_w);
    u_start_o = (cfg_i.yv12 ? plane_b : plane_a) + off_c;
    v_start_o = (cfg_i.yv12 ? plane_a : plane_b) + off_c;
  end
endmodule

// File: rtl/fsag_walker.sv
module fsag_walker
  import fsag_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bnd_i,
  input  logic               line_start_i,
  input  logic               pix_i,
  input  logic [2:0]         bpp_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [ADDR_W-1:0]  y_start_i,
  input  logic [ADDR_W-1:0]  u_start_i,
  input  logic [ADDR_W-1:0]  v_start_i,
  output logic [ADDR_W-1:0]  y_o,
  output logic [ADDR_W-1:0]  u_o,
  output logic [ADDR_W-1:0]  v_o
);
  logic [ADDR_W-1:0] y_row_q, u_row_q, v_row_q, y_q, u_q, v_q;
  logic [ADDR_W-1:0] pitch_w, stride_w;
  logic              first_q, row_odd_q, col_odd_q;

  assign pitch_w  = ADDR_W'(pitch_i);
  assign stride_w = pitch_w << 1;
  assign y_o = y_q;
  assign u_o = u_q;
  assign v_o = v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_row_q   <= '0;
      u_row_q   <= '0;
      v_row_q   <= '0;
      y_q       <= '0;
      u_q       <= '0;
      v_q       <= '0;
      first_q   <= 1'b1;
      row_odd_q <= 1'b0;
      col_odd_q <= 1'b0;
    end else if (bnd_i) begin
      y_row_q   <= y_start_i;
      u_row_q   <= u_start_i;
      v_row_q   <= v_start_i;
      y_q       <= y_start_i;
      u_q       <= u_start_i;
      v_q       <= v_start_i;
      first_q   <= 1'b1;
      row_odd_q <= 1'b0;
      col_odd_q <= 1'b0;
    end else if (line_start_i) begin
      col_odd_q <= 1'b0;
      if (first_q) begin
        first_q <= 1'b0;
        y_q     <= y_row_q;
        u_q     <= u_row_q;
        v_q     <= v_row_q;
      end else begin
        row_odd_q <= ~row_odd_q;
        y_row_q   <= y_row_q + stride_w;
        y_q       <= y_row_q + stride_w;
        if (row_odd_q) begin
          u_row_q <= u_row_q + pitch_w;
          v_row_q <= v_row_q + pitch_w;
          u_q     <= u_row_q + pitch_w;
          v_q     <= v_row_q + pitch_w;
        end else begin
          u_q <= u_row_q;
          v_q <= v_row_q;
        end
      end
    end else if (pix_i) begin
      y_q       <= y_q + ADDR_W'(bpp_i);
      col_odd_q <= ~col_odd_q;
      if (col_odd_q) begin
        u_q <= u_q + ADDR_W'(1);
        v_q <= v_q + ADDR_W'(1);
      end
    end
  end

  AST_LUMA_PIXEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_i && !line_start_i && !bnd_i) |=> (y_q == $past(y_q) + ADDR_W'($past(bpp_i)))); // R6
  AST_CHROMA_PAIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_i && !line_start_i && !bnd_i && !col_odd_q) |=> ($stable(u_q) && $stable(v_q))); // R7
  AST_ROW_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !bnd_i && !first_q) |=> (y_row_q == $past(y_row_q) + (ADDR_W'($past(pitch_i)) << 1))); // R2
endmodule

// File: rtl/field_scan_addr_gen.sv
module field_scan_addr_gen
  import fsag_pkg::*;
#(
  parameter int LINE_W      = 12,
  parameter int GUARD_LINES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_wr_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [PITCH_W-1:0]  pitch_i,
  input  logic [HEIGHT_W-1:0] height_i,
  input  logic [2:0]          depth_i,
  input  logic                uyvy_i,
  input  logic                yv12_i,
  input  logic [LINE_W-1:0]   field_lines_i,
  input  logic                field_i,
  input  logic                line_start_i,
  input  logic                pix_i,
  output logic [ADDR_W-1:0]   y_addr_o,
  output logic [ADDR_W-1:0]   u_addr_o,
  output logic [ADDR_W-1:0]   v_addr_o,
  output logic                filt_en_o,
  output logic                uyvy_o,
  output logic                fmt_err_o
);
  scan_cfg_t         wr_cfg, live_cfg, nxt_cfg;
  logic              field_q, bnd;
  logic [ADDR_W-1:0] y_s, u_s, v_s, y_w, u_w, v_w;
  logic              err, planar;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) field_q <= 1'b0;
    else         field_q <= field_i;
  end
  assign bnd = field_i ^ field_q;

  always_comb begin
    wr_cfg.base   = base_i;
    wr_cfg.pitch  = pitch_i;
    wr_cfg.height = height_i;
    wr_cfg.depth  = depth_i;
    wr_cfg.uyvy   = uyvy_i;
    wr_cfg.yv12   = yv12_i;
  end

  fsag_shadow #(.LINE_W(LINE_W), .GUARD_LINES(GUARD_LINES)) u_shadow (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (cfg_wr_i),
    .wr_cfg_i      (wr_cfg),
    .bnd_i         (bnd),
    .line_start_i  (line_start_i),
    .field_lines_i (field_lines_i),
    .live_o        (live_cfg),
    .nxt_o         (nxt_cfg)
  );

  fsag_start_calc u_start (
    .cfg_i     (nxt_cfg),
    .field_i   (field_i),
    .y_start_o (y_s),
    .u_start_o (u_s),
    .v_start_o (v_s)
  );

  fsag_walker u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bnd_i        (bnd),
    .line_start_i (line_start_i),
    .pix_i        (pix_i),
    .bpp_i        (bytes_per_pix(live_cfg.depth)),
    .pitch_i      (live_cfg.pitch),
    .y_start_i    (y_s),
    .u_start_i    (u_s),
    .v_start_i    (v_s),
    .y_o          (y_w),
    .u_o          (u_w),
    .v_o          (v_w)
  );

  assign err       = !depth_ok(live_cfg.depth);
  assign planar    = live_cfg.depth == DEPTH_PL420;
  assign fmt_err_o = err;
  assign filt_en_o = depth_yuv(live_cfg.depth);
  assign uyvy_o    = live_cfg.uyvy && (live_cfg.depth == DEPTH_PK422);
  assign y_addr_o  = err ? live_cfg.base : y_w;
  assign u_addr_o  = err ? live_cfg.base : (planar ? u_w : '0);
  assign v_addr_o  = err ? live_cfg.base : (planar ? v_w : '0);

  AST_FILTER_ONLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_en_o |-> !fmt_err_o); // R8
  AST_ERR_LUMA_AT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_err_o && $stable(fmt_err_o) && !bnd) |=> $stable(y_addr_o)); // R9
endmodule

// File: tb/field_scan_addr_gen_test.sv
`timescale 1ns/1ps
module field_scan_addr_gen_test;
  import fsag_pkg::*;

  localparam int LINE_W = 12;
  localparam int GUARD  = 2;
  localparam int LINES  = 8;
  localparam int COLS   = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] y, u, v;
    logic err, filt, uy;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, uyvy = 0, yv12 = 0, field = 0, line_start = 0, pix = 0;
  logic [ADDR_W-1:0] base = '0;
  logic [PITCH_W-1:0] pitch = '0;
  logic [HEIGHT_W-1:0] height = '0;
  logic [2:0] depth = 3'b100;
  logic [LINE_W-1:0] field_lines = LINE_W'(LINES);
  logic [ADDR_W-1:0] y_addr, u_addr, v_addr;
  logic filt_en, uyvy_out, fmt_err;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t exp_q[$];
  string tag_q[$];
  scan_cfg_t m_live, m_shadow;
  bit m_pend = 0, m_late = 0, cur_f = 0;
  int m_lines = 0;

  always #2.5 clk = ~clk;

  field_scan_addr_gen #(.LINE_W(LINE_W), .GUARD_LINES(GUARD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .base_i(base), .pitch_i(pitch),
    .height_i(height), .depth_i(depth), .uyvy_i(uyvy), .yv12_i(yv12),
    .field_lines_i(field_lines), .field_i(field), .line_start_i(line_start), .pix_i(pix),
    .y_addr_o(y_addr), .u_addr_o(u_addr), .v_addr_o(v_addr),
    .filt_en_o(filt_en), .uyvy_o(uyvy_out), .fmt_err_o(fmt_err)
  );

  function automatic exp_t model(scan_cfg_t c, bit f, int r, int col);
    exp_t e;
    logic [31:0] p, half, bpp, pa, pb;
    p = 32'(c.pitch);
    half = p >> 1;
    case (c.depth)
      3'b001, 3'b010, 3'b101: bpp = 2;
      3'b100: bpp = 4;
      3'b111: bpp = 1;
      default: bpp = 0;
    endcase
    e.err  = (bpp == 0);
    e.filt = (c.depth == 3'b101) || (c.depth == 3'b111);
    e.uy   = c.uyvy && (c.depth == 3'b101);
    if (e.err) begin
      e.y = c.base; e.u = c.base; e.v = c.base;
      return e;
    end
    e.y = c.base + (f ? 0 : p) + 32'(r) * 2 * p + 32'(col) * bpp;
    if (c.depth == 3'b111) begin
      pa = c.base + 32'(c.height) * p;
      pb = pa + 32'(c.height / 2) * half;
      e.u = (c.yv12 ? pb : pa) + (f ? 0 : half) + 32'(r / 2) * p + 32'(col / 2);
      e.v = (c.yv12 ? pa : pb) + (f ? 0 : half) + 32'(r / 2) * p + 32'(col / 2);
    end else begin
      e.u = '0; e.v = '0;
    end
    return e;
  endfunction

  function automatic scan_cfg_t mk(logic [31:0] b, int p, int h, logic [2:0] d, bit uy, bit y12);
    scan_cfg_t c;
    c.base = b; c.pitch = PITCH_W'(p); c.height = HEIGHT_W'(h);
    c.depth = d; c.uyvy = uy; c.yv12 = y12;
    return c;
  endfunction

  task automatic host_write(scan_cfg_t c);
    base = c.base; pitch = c.pitch; height = c.height;
    depth = c.depth; uyvy = c.uyvy; yv12 = c.yv12;
    cfg_wr = 1;
    @(posedge clk); #1;
    cfg_wr = 0;
    m_shadow = c;
    if (m_lines + GUARD >= LINES) begin m_late = 1; m_pend = 0; end  // R11
    else begin m_pend = 1; m_late = 0; end                         // R10
  endtask

  task automatic run_field(int wr_row, scan_cfg_t wc, string tag);
    cur_f = ~cur_f;
    field = cur_f;
    if (m_pend) begin m_live = m_shadow; m_pend = 0; end
    else if (m_late) begin m_pend = 1; m_late = 0; end
    m_lines = 0;
    @(posedge clk); #1;
    for (int r = 0; r < LINES; r++) begin
      if (r == wr_row) host_write(wc);
      line_start = 1;
      @(posedge clk); #1;
      line_start = 0;
      m_lines++;
      for (int c = 0; c < COLS; c++) begin
        pix = 1;
        exp_q.push_back(model(m_live, cur_f, r, c));
        tag_q.push_back(tag);
        @(posedge clk); #1;
      end
      pix = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pix && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty y=%h", y_addr);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (y_addr !== e.y || u_addr !== e.u || v_addr !== e.v ||
            fmt_err !== e.err || filt_en !== e.filt || uyvy_out !== e.uy) begin
          errors++;
          $display("FAIL %s y=%h/%h u=%h/%h v=%h/%h err=%b/%b filt=%b/%b uyvy=%b/%b",
                   t, y_addr, e.y, u_addr, e.u, v_addr, e.v, fmt_err, e.err,
                   filt_en, e.filt, uyvy_out, e.uy);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    scan_cfg_t cA, cB, cC, cD, cE, cG, cH, cI, cJ, cK;
    m_live = '0; m_live.depth = 3'b100;
    m_shadow = m_live;
    cA = mk(32'h0000_1000, 256, 480, 3'b101, 0, 0);
    cB = mk(32'h0004_0000, 512, 480, 3'b100, 1, 0);
    cC = mk(32'h0002_0000,  64,  16, 3'b111, 0, 0);
    cD = mk(32'h0003_0000, 128,  20, 3'b111, 0, 1);
    cE = mk(32'h0005_0000, 256, 480, 3'b101, 1, 0);
    cG = mk(32'h0006_0000, 320, 480, 3'b010, 0, 0);
    cH = mk(32'h0007_0000, 320, 480, 3'b001, 1, 0);
    cI = mk(32'h0008_0000, 256, 480, 3'b110, 0, 0);
    cJ = mk(32'h0009_0000,  96,  24, 3'b111, 0, 0);
    cK = mk(32'h000A_0000, 160,  12, 3'b111, 0, 1);

    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R12: reset state
    checks++;
    if (y_addr !== '0 || u_addr !== '0 || v_addr !== '0) begin
      errors++;
      $display("FAIL R12 addr y=%h u=%h v=%h expected 0", y_addr, u_addr, v_addr);
    end
    checks++;
    if (fmt_err !== 0 || filt_en !== 0 || uyvy_out !== 0) begin
      errors++;
      $display("FAIL R12 flags err=%b filt=%b uyvy=%b expected 000", fmt_err, filt_en, uyvy_out);
    end
    @(posedge clk); #1;

    host_write(cA);
    run_field(-1, cA, "R1");
    run_field(0,  cB, "R2");
    run_field(3,  cC, "R6");
    run_field(-1, cC, "R3");
    run_field(1,  cD, "R5");
    run_field(0,  cE, "R4");
    run_field(0,  cG, "R8");
    run_field(0,  cH, "R7");
    run_field(0,  cI, "R6");
    run_field(2,  cJ, "R9");
    run_field(6,  cK, "R10");
    run_field(-1, cK, "R11");
    run_field(-1, cK, "R11");

    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 pixels left unchecked=%0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule